// File: doc/BRIEF.md
# Display Control Register Decoder

This block sits behind the display control port of a graphics unit. Every 32-bit write carries a command code in its top byte and a payload below it. The decoder applies the command to a 32-bit status word. It also applies it to a set of display-area registers: the scan-out start point and the horizontal and vertical display ranges. Query commands load a read-back latch with masked copies of the environment registers.

The decoder keeps the last word written for each low command slot. It drops a write that repeats the stored word, except for the two reset commands and the display-start command. It pulses a flush strobe when a reset command asks the drawing path to drain. It pulses a dims-changed strobe when the display ranges or the display mode change. A separate read port returns the status word or the latch without side effects. The horizontal mode field is also decoded into a nominal pixel width and a dot-clock divider.

Top module: `dispctl_decoder`

## Requirements
- R1: After `rst` (synchronous, active high) the status word is 0x14802000. The latch, display start and both ranges are zero. `flush_pulse` and `dims_changed` are low.
- R2: Command 0x00 restores every register to its R1 value and clears all stored command words except slot 3, which is set to 1. It raises `flush_pulse` for one cycle.
- R3: Command 0x01 raises `flush_pulse` for one cycle and leaves all other state unchanged. It is never dropped as a repeat.
- R4: Command 0x03 copies payload bit 0 into status bit 23 (blanking).
- R5: Command 0x04 copies payload bits 1:0 into status bits 30:29 (transfer direction).
- R6: Command 0x05 loads start X from bits 9:0 and start Y from bits 18:10. Higher bits are ignored.
- R7: Command 0x06 loads horizontal first/last from bits 11:0 and 23:12. Command 0x07 loads vertical first/last from bits 9:0 and 19:10.
- R8: Command 0x08 rewrites status bits 22:16. Payload bits 5:0 go to status 22:17 and payload bit 6 goes to status 16. No other status bit changes.
- R9: Status bits 18:16 select the width and divider. Even index 0/2/4/6 gives widths 256/320/512/640 with dividers 10/8/5/4. Any odd index gives 368 with divider 7.
- R10: Commands 0x10 to 0x1F act on payload bits 3:0:
  - 2, 3 or 4: the latch takes environment word [bits 2:0] AND 0xFFFFF.
  - 5: the latch takes environment word 5 AND 0x3FFFFF.
  - 7: the latch takes 2.
  - Any other value: the latch is unchanged.
- R11: A write whose command is 2 to 15, other than 5, is dropped with no effect when it equals the stored word for that command.
- R12: `dims_changed` is high for one cycle after each accepted command 0x06, 0x07 or 0x08, and at no other time.
- R13: `rd_data` returns the status word when `rd_sel` is 0 and the latch when it is 1.
- R14: Commands with no listed meaning (for example 0x09, 0x20, 0xE1) change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control port |
| wr_data | input | 32 | Command byte [31:24] and payload |
| env_flat | input | 256 | Eight 32-bit environment words, word k at bits 32k+31:32k |
| rd_sel | input | 1 | Read select: 0 status, 1 latch |
| rd_data | output | 32 | Read-back data |
| flush_pulse | output | 1 | One-cycle drain request |
| dims_changed | output | 1 | One-cycle geometry change strobe |
| start_x | output | 10 | Display start X |
| start_y | output | 9 | Display start Y |
| h_first | output | 12 | Horizontal range start |
| h_last | output | 12 | Horizontal range end |
| v_first | output | 10 | Vertical range start |
| v_last | output | 10 | Vertical range end |
| h_res | output | 10 | Nominal width from mode index |
| h_div | output | 4 | Dot-clock divider from mode index |

## Verification
The mode command is driven with payloads that set only the low field bits, then bit 6 together with bit 0, then a single mid bit. This separates the bit remap from a straight copy and shows that the transfer-direction and blanking bits survive. Queries use environment words with high bits set, so a missing mask shows up. Queries also use low nibbles whose bits 2:0 alias a valid selector, such as 0xB, which must leave the latch unchanged. Repeat writes are watched through the strobes. A repeated range write gives no `dims_changed`, a repeated drain command still pulses, and a repeat after a full reset is accepted again.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;

    localparam int WORD_W      = 32;
    localparam int CMD_W       = 8;
    localparam int PAY_W       = WORD_W - CMD_W;
    localparam int ENV_COUNT   = 8;
    localparam int ENV_IDX_W   = $clog2(ENV_COUNT);
    localparam int SX_W        = 10;
    localparam int SY_W        = 9;
    localparam int HR_W        = 12;
    localparam int VR_W        = 10;
    localparam int RES_W       = 10;
    localparam int DIV_W       = 4;

    localparam logic [WORD_W-1:0] STATUS_INIT = 32'h1480_2000;
    localparam int BLANK_BIT   = 23;
    localparam int DMA_LO      = 29;
    localparam int DMA_HI      = 30;
    localparam int MODE_LO     = 16;
    localparam int MODE_HI     = 22;

    localparam logic [WORD_W-1:0] MASK_NARROW  = 32'h000F_FFFF;
    localparam logic [WORD_W-1:0] MASK_WIDE    = 32'h003F_FFFF;
    localparam logic [WORD_W-1:0] VERSION_WORD = 32'h0000_0002;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_RESET,
        OP_FLUSH,
        OP_BLANK,
        OP_DMA,
        OP_START,
        OP_HRANGE,
        OP_VRANGE,
        OP_MODE,
        OP_QUERY
    } op_e;

    typedef struct packed {
        op_e              op;
        logic [PAY_W-1:0] pay;
    } action_t;

    function automatic logic [RES_W-1:0] mode_width(input logic [2:0] idx);
        if (idx[0]) return RES_W'(368);
        case (idx[2:1])
            2'd0:    return RES_W'(256);
            2'd1:    return RES_W'(320);
            2'd2:    return RES_W'(512);
            default: return RES_W'(640);
        endcase
    endfunction

    function automatic logic [DIV_W-1:0] mode_divider(input logic [2:0] idx);
        if (idx[0]) return DIV_W'(7);
        case (idx[2:1])
            2'd0:    return DIV_W'(10);
            2'd1:    return DIV_W'(8);
            2'd2:    return DIV_W'(5);
            default: return DIV_W'(4);
        endcase
    endfunction

endpackage

// File: rtl/dispctl_shadow.sv
module dispctl_shadow
    import dispctl_pkg::*;
#(
    parameter int SLOT_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              repeat_hit
);
    localparam int SLOT_IDX_W = $clog2(SLOT_COUNT);
    localparam int RESET_SLOT = 3;

    logic [WORD_W-1:0] slot_q [SLOT_COUNT];
    logic [CMD_W-1:0]  cmd;
    logic              in_range;
    logic              exempt;
    logic              accept;

    assign cmd      = wr_data[WORD_W-1 -: CMD_W];
    assign in_range = int'(cmd) < SLOT_COUNT;
    assign exempt   = (cmd == 8'h00) || (cmd == 8'h01) || (cmd == 8'h05);

    always_comb begin
        repeat_hit = 1'b0;
        if (wr_en && in_range && !exempt)
            repeat_hit = (slot_q[cmd[SLOT_IDX_W-1:0]] == wr_data);
    end

    assign accept = wr_en && !repeat_hit;

    for (genvar g = 0; g < SLOT_COUNT; g++) begin : g_slot
        localparam logic [WORD_W-1:0] CLEAR_VAL =
            (g == RESET_SLOT) ? WORD_W'(1) : '0;
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= CLEAR_VAL;
            end else if (accept) begin
                if (cmd == 8'h00)
                    slot_q[g] <= CLEAR_VAL;
                else if (cmd == CMD_W'(g))
                    slot_q[g] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/dispctl_decode.sv
module dispctl_decode
    import dispctl_pkg::*;
(
    input  logic              wr_en,
    input  logic              repeat_hit,
    input  logic [WORD_W-1:0] wr_data,
    output action_t           act
);
    logic [CMD_W-1:0] cmd;
    assign cmd = wr_data[WORD_W-1 -: CMD_W];

    always_comb begin
        act.pay = wr_data[PAY_W-1:0];
        act.op  = OP_NONE;
        if (wr_en && !repeat_hit) begin
            case (cmd)
                8'h00:   act.op = OP_RESET;
                8'h01:   act.op = OP_FLUSH;
                8'h03:   act.op = OP_BLANK;
                8'h04:   act.op = OP_DMA;
                8'h05:   act.op = OP_START;
                8'h06:   act.op = OP_HRANGE;
                8'h07:   act.op = OP_VRANGE;
                8'h08:   act.op = OP_MODE;
                default: act.op = (cmd[7:4] == 4'h1) ? OP_QUERY : OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/dispctl_state.sv
module dispctl_state
    import dispctl_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  action_t                     act,
    input  logic [ENV_COUNT*WORD_W-1:0] env_flat,
    output logic [WORD_W-1:0]           status_q,
    output logic [WORD_W-1:0]           latch_q,
    output logic [SX_W-1:0]             sx_q,
    output logic [SY_W-1:0]             sy_q,
    output logic [HR_W-1:0]             hx1_q,
    output logic [HR_W-1:0]             hx2_q,
    output logic [VR_W-1:0]             vy1_q,
    output logic [VR_W-1:0]             vy2_q,
    output logic                        flush_q,
    output logic                        dims_q
);
    localparam int MODE_W = MODE_HI - MODE_LO + 1;

    logic [WORD_W-1:0] env_w [ENV_COUNT];
    logic              query_hit;
    logic [WORD_W-1:0] query_val;

    for (genvar g = 0; g < ENV_COUNT; g++) begin : g_env
        assign env_w[g] = env_flat[g*WORD_W +: WORD_W];
    end

    always_comb begin
        query_hit = 1'b1;
        query_val = '0;
        case (act.pay[3:0])
            4'h2, 4'h3, 4'h4: query_val = env_w[act.pay[ENV_IDX_W-1:0]] & MASK_NARROW;
            4'h5:             query_val = env_w[5] & MASK_WIDE;
            4'h7:             query_val = VERSION_WORD;
            default:          query_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= STATUS_INIT;
            latch_q  <= '0;
            sx_q     <= '0;
            sy_q     <= '0;
            hx1_q    <= '0;
            hx2_q    <= '0;
            vy1_q    <= '0;
            vy2_q    <= '0;
            flush_q  <= 1'b0;
            dims_q   <= 1'b0;
        end else begin
            flush_q <= 1'b0;
            dims_q  <= 1'b0;
            case (act.op)
                OP_RESET: begin
                    status_q <= STATUS_INIT;
                    latch_q  <= '0;
                    sx_q     <= '0;
                    sy_q     <= '0;
                    hx1_q    <= '0;
                    hx2_q    <= '0;
                    vy1_q    <= '0;
                    vy2_q    <= '0;
                    flush_q  <= 1'b1;
                end
                OP_FLUSH:  flush_q <= 1'b1;
                OP_BLANK:  status_q[BLANK_BIT] <= act.pay[0];
                OP_DMA:    status_q[DMA_HI:DMA_LO] <= act.pay[1:0];
                OP_START: begin
                    sx_q <= act.pay[SX_W-1:0];
                    sy_q <= act.pay[10 +: SY_W];
                end
                OP_HRANGE: begin
                    hx1_q  <= act.pay[HR_W-1:0];
                    hx2_q  <= act.pay[HR_W +: HR_W];
                    dims_q <= 1'b1;
                end
                OP_VRANGE: begin
                    vy1_q  <= act.pay[VR_W-1:0];
                    vy2_q  <= act.pay[VR_W +: VR_W];
                    dims_q <= 1'b1;
                end
                OP_MODE: begin
                    status_q[MODE_HI:MODE_LO] <= MODE_W'({act.pay[5:0], act.pay[6]});
                    dims_q <= 1'b1;
                end
                OP_QUERY: if (query_hit) latch_q <= query_val;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/dispctl_decoder.sv
module dispctl_decoder
    import dispctl_pkg::*;
#(
    parameter int SLOT_COUNT = 16
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [ENV_COUNT*WORD_W-1:0] env_flat,
    input  logic                        rd_sel,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        flush_pulse,
    output logic                        dims_changed,
    output logic [SX_W-1:0]             start_x,
    output logic [SY_W-1:0]             start_y,
    output logic [HR_W-1:0]             h_first,
    output logic [HR_W-1:0]             h_last,
    output logic [VR_W-1:0]             v_first,
    output logic [VR_W-1:0]             v_last,
    output logic [RES_W-1:0]            h_res,
    output logic [DIV_W-1:0]            h_div
);
    logic              repeat_hit;
    action_t           act;
    logic [WORD_W-1:0] status_q;
    logic [WORD_W-1:0] latch_q;

    dispctl_shadow #(.SLOT_COUNT(SLOT_COUNT)) u_shadow (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .repeat_hit (repeat_hit)
    );

    dispctl_decode u_decode (
        .wr_en      (wr_en),
        .repeat_hit (repeat_hit),
        .wr_data    (wr_data),
        .act        (act)
    );

    dispctl_state u_state (
        .clk      (clk),
        .rst      (rst),
        .act      (act),
        .env_flat (env_flat),
        .status_q (status_q),
        .latch_q  (latch_q),
        .sx_q     (start_x),
        .sy_q     (start_y),
        .hx1_q    (h_first),
        .hx2_q    (h_last),
        .vy1_q    (v_first),
        .vy2_q    (v_last),
        .flush_q  (flush_pulse),
        .dims_q   (dims_changed)
    );

    assign rd_data = rd_sel ? latch_q : status_q;
    assign h_res   = mode_width(status_q[MODE_LO +: 3]);
    assign h_div   = mode_divider(status_q[MODE_LO +: 3]);

endmodule

// File: rtl/dispctl_checker.sv
module dispctl_checker (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [31:0] wr_data,
    input logic [31:0] status_q,
    input logic [31:0] latch_q,
    input logic        flush_pulse,
    input logic        dims_changed,
    input logic [3:0]  h_div
);
    logic [7:0] cmd;
    assign cmd = wr_data[31:24];

    AST_RESET_STATUS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == 8'h00) |=> (status_q == 32'h1480_2000 && latch_q == 32'h0)); // R2
    AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == 8'h01) |=> flush_pulse); // R3
    AST_BLANK_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == 8'h03) |=> status_q[23] == $past(wr_data[0])); // R4
    AST_DMA_FIELD: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == 8'h04) |=> status_q[30:29] == $past(wr_data[1:0])); // R5
    AST_MODE_LOW_BIT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd == 8'h08) |=> status_q[16] == $past(wr_data[6])); // R8
    AST_DIV_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (h_div == 4'd4 || h_div == 4'd5 || h_div == 4'd7 || h_div == 4'd8 || h_div == 4'd10)); // R9
    AST_QUERY_VERSION: assert property (@(posedge clk) disable iff (rst)
        (wr_en && cmd[7:4] == 4'h1 && wr_data[3:0] == 4'h7) |=> latch_q == 32'h2); // R10
    AST_DIMS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        dims_changed |-> ($past(wr_en) && ($past(cmd) == 8'h06 || $past(cmd) == 8'h07 || $past(cmd) == 8'h08))); // R12

endmodule

bind dispctl_decoder dispctl_checker u_checker (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .status_q     (status_q),
    .latch_q      (latch_q),
    .flush_pulse  (flush_pulse),
    .dims_changed (dims_changed),
    .h_div        (h_div)
);

// File: tb/dispctl_decoder_bench.sv
`timescale 1ns/1ps
module dispctl_decoder_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [31:0]  wr_data = '0;
    logic [255:0] env_flat;
    logic         rd_sel = 1'b0;
    logic [31:0]  rd_data;
    logic         flush_pulse, dims_changed;
    logic [9:0]   start_x;
    logic [8:0]   start_y;
    logic [11:0]  h_first, h_last;
    logic [9:0]   v_first, v_last;
    logic [9:0]   h_res;
    logic [3:0]   h_div;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;
    logic [31:0] exp_status;
    logic [31:0] exp_latch;

    always #2 clk = ~clk;

    dispctl_decoder u_dispctl_decoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .env_flat(env_flat), .rd_sel(rd_sel), .rd_data(rd_data),
        .flush_pulse(flush_pulse), .dims_changed(dims_changed),
        .start_x(start_x), .start_y(start_y), .h_first(h_first), .h_last(h_last),
        .v_first(v_first), .v_last(v_last), .h_res(h_res), .h_div(h_div)
    );

    function automatic logic [31:0] env_word(input int k);
        return 32'hCFF0_0F50 ^ (32'(k) << 24) ^ (32'(k) * 32'h0001_1111);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic read_both(output logic [31:0] st, output logic [31:0] la);
        rd_sel = 1'b0; #0.1 st = rd_data;
        rd_sel = 1'b1; #0.1 la = rd_data;
        rd_sel = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] st, la;
        read_both(st, la);
        check("R1 status", st, 32'h1480_2000);
        check("R13 latch read", la, 32'h0);
        check("R1 start", {13'b0, start_y, start_x}, 32'h0);
        check("R1 strobes", {30'b0, flush_pulse, dims_changed}, 32'h0);
    endtask

    task automatic t_blank();
        logic [31:0] st, la;
        wr(32'h0300_0000); exp_status = 32'h1400_2000;
        read_both(st, la); check("R4 blank clear", st, exp_status);
        wr(32'h0300_0001); exp_status = 32'h1480_2000;
        read_both(st, la); check("R4 blank set", st, exp_status);
    endtask

    task automatic t_dma();
        logic [31:0] st, la;
        wr(32'h0400_0002); exp_status = 32'h5480_2000;
        read_both(st, la); check("R5 dma 2", st, exp_status);
        wr(32'h04FF_FFF3); exp_status = 32'h7480_2000;
        read_both(st, la); check("R5 dma 3", st, exp_status);
    endtask

    task automatic t_start();
        wr(32'h05FF_FE55);
        check("R6 start x", 32'(start_x), 32'h255);
        check("R6 start y", 32'(start_y), 32'h1FF);
        check("R12 no dims on start", 32'(dims_changed), 32'h0);
    endtask

    task automatic t_ranges();
        wr(32'h06AB_C123);
        check("R7 h first", 32'(h_first), 32'h123);
        check("R7 h last", 32'(h_last), 32'hABC);
        check("R12 dims on hrange", 32'(dims_changed), 32'h1);
        idle();
        check("R12 dims one cycle", 32'(dims_changed), 32'h0);
        wr(32'h070C_8064);
        check("R7 v first", 32'(v_first), 32'h064);
        check("R7 v last", 32'(v_last), 32'h320);
        check("R12 dims on vrange", 32'(dims_changed), 32'h1);
    endtask

    task automatic t_mode();
        logic [31:0] st, la;
        wr(32'h0800_0003); exp_status = 32'h7486_2000;
        read_both(st, la); check("R8 mode low bits", st, exp_status);
        check("R12 dims on mode", 32'(dims_changed), 32'h1);
        check("R9 width idx6", 32'(h_res), 32'd640);
        check("R9 div idx6", 32'(h_div), 32'd4);
        wr(32'h0800_0041); exp_status = 32'h7483_2000;
        read_both(st, la); check("R8 mode bit6", st, exp_status);
        check("R9 width idx3", 32'(h_res), 32'd368);
        check("R9 div idx3", 32'(h_div), 32'd7);
        wr(32'h0800_0002); exp_status = 32'h7484_2000;
        read_both(st, la); check("R8 mode mid", st, exp_status);
        check("R9 width idx4", 32'(h_res), 32'd512);
        check("R9 div idx4", 32'(h_div), 32'd5);
    endtask

    task automatic t_query();
        logic [31:0] st, la;
        wr(32'h1000_0002); exp_latch = env_word(2) & 32'h000F_FFFF;
        read_both(st, la); check("R10 query 2", la, exp_latch);
        wr(32'h1000_000B);
        read_both(st, la); check("R10 nibble B unchanged", la, exp_latch);
        wr(32'h1F00_0004); exp_latch = env_word(4) & 32'h000F_FFFF;
        read_both(st, la); check("R10 query 4", la, exp_latch);
        wr(32'h1000_0005); exp_latch = env_word(5) & 32'h003F_FFFF;
        read_both(st, la); check("R10 query 5", la, exp_latch);
        wr(32'h1000_0003); exp_latch = env_word(3) & 32'h000F_FFFF;
        read_both(st, la); check("R10 query 3", la, exp_latch);
        wr(32'h1000_000C);
        read_both(st, la); check("R10 nibble C unchanged", la, exp_latch);
        wr(32'h1000_0007); exp_latch = 32'h2;
        read_both(st, la); check("R10 query 7", la, exp_latch);
        check("R13 status kept", st, exp_status);
    endtask

    task automatic t_ignore();
        logic [31:0] st, la;
        wr(32'h0912_3456);
        check("R14 no dims 09", 32'(dims_changed), 32'h0);
        wr(32'h20FF_FFFF);
        wr(32'hE100_0000);
        check("R14 no strobe", {30'b0, flush_pulse, dims_changed}, 32'h0);
        read_both(st, la);
        check("R14 status", st, exp_status);
        check("R14 latch", la, exp_latch);
        check("R14 h range", {8'b0, h_last, h_first}, 32'h00AB_C123);
    endtask

    task automatic t_repeat();
        wr(32'h0600_0777);
        check("R11 first accepted", 32'(dims_changed), 32'h1);
        wr(32'h0600_0777);
        check("R11 repeat dropped", 32'(dims_changed), 32'h0);
        check("R11 range kept", 32'(h_first), 32'h777);
        wr(32'h0100_0000);
        check("R3 flush", 32'(flush_pulse), 32'h1);
        wr(32'h0100_0000);
        check("R3 flush repeat", 32'(flush_pulse), 32'h1);
        check("R3 range untouched", 32'(h_first), 32'h777);
    endtask

    task automatic t_full_reset();
        logic [31:0] st, la;
        wr(32'h0000_0000); exp_status = 32'h1480_2000; exp_latch = '0;
        read_both(st, la);
        check("R2 status", st, exp_status);
        check("R2 latch", la, exp_latch);
        check("R2 flush", 32'(flush_pulse), 32'h1);
        check("R2 ranges", {8'b0, h_last, h_first}, 32'h0);
        wr(32'h0600_0777);
        check("R2 slot cleared", 32'(dims_changed), 32'h1);
        wr(32'h0300_0000);
        read_both(st, la);
        check("R2 slot3 not zero word", st, 32'h1400_2000);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) env_flat[k*32 +: 32] = env_word(k);
        exp_status = 32'h1480_2000;
        exp_latch  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle();
        t_reset();
        t_blank();
        t_dma();
        t_start();
        t_ranges();
        t_mode();
        t_query();
        t_ignore();
        t_repeat();
        t_full_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

endmodule